// File: doc/BRIEF.md
# Overlap-Two Membership Degree Unit

This block turns one crisp input word into the compact fuzzy description that a rule base needs when no more than two membership functions are active at any input value. Each accepted sample yields a triple: a label, which is the index of the leftmost active function, a first degree for that function, and a second degree for its right-hand neighbour. A downstream rule stage uses the label to select two rule rows and uses the two degrees as their weights. It never has to scan every membership function.

The input axis is split into falling segments. Segment k starts at `LEAD + k*STEP`, where `STEP = 2^IN_W / N_MF` and `LEAD = STEP/2`. Over `STEP - PLATEAU` codes the degree of function k drops from full scale to zero. For the rest of the segment the neighbour stays at full scale, which forms a plateau. Below the first segment the leftmost function sits at full scale, and past the last segment the rightmost one does. This shapes shouldered triangles at the edges and trapezoids inside. The functions are normalized, so the two degrees always add up to full scale.

Each triple comes from one of two sources. In arithmetic mode it is computed from the segment starts and a slope. In memory mode it is read from a table addressed by the input value, and the table contents are computed when the design is elaborated. The result is held in an output register, with valid/ready handshakes on both sides.

Top module: `mf_pair_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its triple appears with `out_valid`=1 after that edge. `out_valid` falls after an edge with `out_ready`=1 and no new acceptance.
- R3: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the label and both degrees stay unchanged.
- R4: The label is the largest k in 0..N_MF-2 with `in_x >= LEAD + k*STEP`. It is 0 when `in_x` is below `LEAD`.
- R5: The first degree is `FULL - m*(in_x - start(label))`, clipped at 0, where `FULL = 2^DEG_W-1` and `m = ceil(FULL/(STEP-PLATEAU))`. It is `FULL` when `in_x < LEAD`.
- R6: The second degree equals `FULL` minus the first degree.
- R7: With `USE_MEM`=1 the triple is read from the table and is identical to the triple defined by R4 to R6 for every input.
- R8: When `m` does not fit in `SLOPE_W` bits, the block uses the table even with `USE_MEM`=0, so the results still match R4 to R6 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_x | input | IN_W | Crisp input value |
| out_valid | output | 1 | Triple present |
| out_ready | input | 1 | Consumer takes the triple |
| out_label | output | LBL_W | Index of leftmost active function |
| out_deg1 | output | DEG_W | Degree of the labelled function |
| out_deg2 | output | DEG_W | Degree of its right neighbour |

## Verification
On every cycle, the assertions check the handshake: an accepted sample fills the register, a stalled triple stays frozen, input is blocked while stalled, and the register drains. On every valid cycle they also check that the two degrees sum to full scale and that the label stays in range. The actual values of the label and the first degree, including the segment edges, the clipped region and the plateaus, can only be confirmed by the bench's scenarios against its own model. The bench also shows that memory mode gives the same triples as arithmetic mode, and that a too-narrow slope width silently falls back to the exact table.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;

  // start code of falling segment k
  function automatic int unsigned seg_start(input int unsigned k, input int unsigned step,
                                            input int unsigned lead);
    return lead + k * step;
  endfunction

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  // last segment whose start lies at or below x; 0 below the first one
  function automatic int unsigned seg_label(input int unsigned x, input int unsigned nseg,
                                            input int unsigned step, input int unsigned lead);
    int unsigned lab;
    lab = 0;
    for (int unsigned k = 0; k < nseg; k++)
      if (x >= seg_start(k, step, lead)) lab = k;
    return lab;
  endfunction

  // falling degree, clipped to zero
  function automatic int unsigned sat_degree(input int unsigned full, input int unsigned slope,
                                             input int unsigned offs);
    int unsigned p;
    p = slope * offs;
    return (p >= full) ? 0 : full - p;
  endfunction

endpackage

// File: rtl/mf_seg_locate.sv
`timescale 1ns/1ps
module mf_seg_locate #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned N_SEG = 4,
  parameter int unsigned LBL_W = 2,
  parameter int unsigned STEP  = 51,
  parameter int unsigned LEAD  = 25
) (
  input  logic [IN_W-1:0]  x,
  output logic [LBL_W-1:0] label,
  output logic [IN_W-1:0]  offset
);
  logic [IN_W-1:0]  base [N_SEG];
  logic [N_SEG-1:0] past;

  for (genvar k = 0; k < N_SEG; k++) begin : g_seg
    assign base[k] = IN_W'(mfp_pkg::seg_start(k, STEP, LEAD));
    assign past[k] = (x >= base[k]);
  end

  // starts are ascending, so the last hit is the largest index
  always_comb begin
    label  = '0;
    offset = '0;
    for (int k = 0; k < N_SEG; k++) begin
      if (past[k]) begin
        label  = LBL_W'(k);
        offset = x - base[k];
      end
    end
  end
endmodule

// File: rtl/mf_degree_calc.sv
`timescale 1ns/1ps
module mf_degree_calc #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned DEG_W   = 8,
  parameter int unsigned SLOPE_W = 8,
  parameter int unsigned SLOPE   = 7
) (
  input  logic [IN_W-1:0]  offset,
  output logic [DEG_W-1:0] deg1,
  output logic [DEG_W-1:0] deg2
);
  localparam int unsigned PW   = IN_W + SLOPE_W;
  localparam int unsigned FULL = (1 << DEG_W) - 1;
  localparam logic [SLOPE_W-1:0] M = SLOPE_W'(SLOPE);

  logic [PW-1:0] prod;
  assign prod = PW'(offset) * PW'(M);
  assign deg1 = (prod >= PW'(FULL)) ? '0 : DEG_W'(PW'(FULL) - prod);
  assign deg2 = DEG_W'(FULL) - deg1;
endmodule

// File: rtl/mf_triple_rom.sv
`timescale 1ns/1ps
module mf_triple_rom #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned DEG_W = 8,
  parameter int unsigned LBL_W = 2,
  parameter int unsigned N_SEG = 4,
  parameter int unsigned STEP  = 51,
  parameter int unsigned LEAD  = 25,
  parameter int unsigned SLOPE = 7
) (
  input  logic [IN_W-1:0]  addr,
  output logic [LBL_W-1:0] label,
  output logic [DEG_W-1:0] deg1,
  output logic [DEG_W-1:0] deg2
);
  localparam int unsigned DEPTH = 1 << IN_W;
  localparam int unsigned WW    = LBL_W + 2 * DEG_W;
  localparam int unsigned FULL  = (1 << DEG_W) - 1;

  logic [WW-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    localparam int unsigned LB  = mfp_pkg::seg_label(a, N_SEG, STEP, LEAD);
    localparam int unsigned OFS = (a >= LEAD) ? a - mfp_pkg::seg_start(LB, STEP, LEAD) : 0;
    localparam int unsigned D1  = mfp_pkg::sat_degree(FULL, SLOPE, OFS);
    assign tbl[a] = {LBL_W'(LB), DEG_W'(D1), DEG_W'(FULL - D1)};
  end

  assign {label, deg1, deg2} = tbl[addr];
endmodule

// File: rtl/mf_pair_unit.sv
`timescale 1ns/1ps
module mf_pair_unit #(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned DEG_W   = 8,
  parameter int unsigned SLOPE_W = 8,
  parameter int unsigned N_MF    = 5,
  parameter int unsigned PLATEAU = 11,
  parameter bit          USE_MEM = 1'b0,
  localparam int unsigned N_SEG  = N_MF - 1,
  localparam int unsigned LBL_W  = (N_SEG > 1) ? $clog2(N_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_x,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LBL_W-1:0] out_label,
  output logic [DEG_W-1:0] out_deg1,
  output logic [DEG_W-1:0] out_deg2
);
  localparam int unsigned FULL       = (1 << DEG_W) - 1;
  localparam int unsigned STEP       = (1 << IN_W) / N_MF;
  localparam int unsigned LEAD       = STEP / 2;
  localparam int unsigned FALL_W     = STEP - PLATEAU;
  localparam int unsigned SLOPE      = mfp_pkg::ceil_div(FULL, FALL_W);
  localparam bit          SLOPE_FITS = SLOPE < (1 << SLOPE_W);
  localparam bit          MEM_MODE   = USE_MEM || !SLOPE_FITS;

  logic             acc_fire;
  logic [LBL_W-1:0] nx_label;
  logic [DEG_W-1:0] nx_d1;
  logic [DEG_W-1:0] nx_d2;

  if (MEM_MODE) begin : g_mem
    mf_triple_rom #(
      .IN_W(IN_W), .DEG_W(DEG_W), .LBL_W(LBL_W), .N_SEG(N_SEG),
      .STEP(STEP), .LEAD(LEAD), .SLOPE(SLOPE)
    ) u_rom (
      .addr(in_x), .label(nx_label), .deg1(nx_d1), .deg2(nx_d2)
    );
  end else begin : g_arith
    logic [IN_W-1:0] seg_off;
    mf_seg_locate #(
      .IN_W(IN_W), .N_SEG(N_SEG), .LBL_W(LBL_W), .STEP(STEP), .LEAD(LEAD)
    ) u_loc (
      .x(in_x), .label(nx_label), .offset(seg_off)
    );
    mf_degree_calc #(
      .IN_W(IN_W), .DEG_W(DEG_W), .SLOPE_W(SLOPE_W), .SLOPE(SLOPE)
    ) u_deg (
      .offset(seg_off), .deg1(nx_d1), .deg2(nx_d2)
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign acc_fire = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_label <= '0;
      out_deg1  <= '0;
      out_deg2  <= '0;
    end else begin
      if (acc_fire) begin
        out_valid <= 1'b1;
        out_label <= nx_label;
        out_deg1  <= nx_d1;
        out_deg2  <= nx_d2;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mf_pair_unit_chk.sv
`timescale 1ns/1ps
module mf_pair_unit_chk #(
  parameter int unsigned DEG_W = 8,
  parameter int unsigned LBL_W = 2,
  parameter int unsigned N_SEG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LBL_W-1:0] out_label,
  input logic [DEG_W-1:0] out_deg1,
  input logic [DEG_W-1:0] out_deg2,
  input logic             acc_fire
);
  localparam int unsigned FULL = (1 << DEG_W) - 1;

  assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && acc_fire |=> out_valid);

  assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !acc_fire |=> !out_valid);

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_label) && $stable(out_deg1)
                                && $stable(out_deg2));

  assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_label_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_label) <= N_SEG - 1);

  assert_normalized_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_deg1) + 32'(out_deg2) == FULL);
endmodule

bind mf_pair_unit mf_pair_unit_chk #(.DEG_W(DEG_W), .LBL_W(LBL_W), .N_SEG(N_SEG)) u_chk (.*);

// File: tb/mf_pair_unit_tb.sv
`timescale 1ns/1ps
module mf_pair_unit_tb;
  localparam int IN_W = 8, DEG_W = 8, N_MF = 5, PLAT = 11, LBL_W = 2;
  // model constants restated from the requirements
  localparam int FULL = 255;
  localparam int STEP = 256 / N_MF;
  localparam int LEAD = STEP / 2;
  localparam int M    = (FULL + (STEP - PLAT) - 1) / (STEP - PLAT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_x = '0;
  logic out_ready = 1'b0;
  logic [2:0] rdy;
  logic [2:0] vld;
  logic [LBL_W-1:0] lab [3];
  logic [DEG_W-1:0] d1 [3];
  logic [DEG_W-1:0] d2 [3];

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  // 0: arithmetic, 1: table, 2: slope too narrow -> table forced
  mf_pair_unit #(.SLOPE_W(8), .USE_MEM(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]), .in_x(in_x),
    .out_valid(vld[0]), .out_ready(out_ready), .out_label(lab[0]), .out_deg1(d1[0]),
    .out_deg2(d2[0]));
  mf_pair_unit #(.SLOPE_W(8), .USE_MEM(1'b1)) u_mem (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]), .in_x(in_x),
    .out_valid(vld[1]), .out_ready(out_ready), .out_label(lab[1]), .out_deg1(d1[1]),
    .out_deg2(d2[1]));
  mf_pair_unit #(.SLOPE_W(2), .USE_MEM(1'b0)) u_nar (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]), .in_x(in_x),
    .out_valid(vld[2]), .out_ready(out_ready), .out_label(lab[2]), .out_deg1(d1[2]),
    .out_deg2(d2[2]));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_label(input int x);
    int l = 0;
    for (int k = 0; k < N_MF - 1; k++) if (x >= LEAD + k * STEP) l = k;
    return l;
  endfunction

  function automatic int exp_deg1(input int x);
    int off, p;
    if (x < LEAD) return FULL;
    off = x - (LEAD + exp_label(x) * STEP);
    p = M * off;
    return (p > FULL) ? 0 : FULL - p;
  endfunction

  task automatic check_triple(input int x);
    string tag [3] = '{"R5", "R7", "R8"};
    for (int i = 0; i < 3; i++) begin
      check(int'(lab[i]) == exp_label(x), (i == 0) ? "R4" : tag[i], "label",
            int'(lab[i]), exp_label(x));
      check(int'(d1[i]) == exp_deg1(x), tag[i], "deg1", int'(d1[i]), exp_deg1(x));
      check(int'(d2[i]) == FULL - exp_deg1(x), (i == 0) ? "R6" : tag[i], "deg2",
            int'(d2[i]), FULL - exp_deg1(x));
    end
  endtask

  task automatic run_one(input int x, input int stall);
    @(negedge clk);
    check(rdy == 3'b111, "R2", "in_ready before send", int'(rdy), 7);
    in_valid = 1'b1;
    in_x = IN_W'(x);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    in_x = IN_W'($urandom);
    check(vld == 3'b111, "R2", "out_valid after accept", int'(vld), 7);
    check_triple(x);
    for (int s = 0; s < stall; s++) begin
      in_valid = 1'b1;               // offered while stalled: must be refused
      @(negedge clk);
      in_valid = 1'b0;
      check(rdy == 3'b000, "R3", "in_ready while stalled", int'(rdy), 0);
      check(vld == 3'b111, "R3", "out_valid while stalled", int'(vld), 7);
      check_triple(x);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(vld == 3'b000, "R2", "out_valid after drain", int'(vld), 0);
  endtask

  initial begin
    #(4ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(vld == 3'b000, "R1", "out_valid in reset", int'(vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vld == 3'b000, "R1", "out_valid after reset", int'(vld), 0);
    check(rdy == 3'b111, "R1", "in_ready after reset", int'(rdy), 7);

    // directed: below first segment, edges, clip point, plateau, top shoulder
    begin
      int pts [14] = '{0, 24, 25, 26, 60, 61, 65, 75, 76, 127, 178, 217, 219, 255};
      foreach (pts[i]) run_one(pts[i], i % 3);
    end
    // random samples with random stall length
    for (int n = 0; n < 400; n++) run_one(int'($urandom % 256), int'($urandom % 3));

    // back-to-back acceptance with the consumer always ready
    @(negedge clk);
    out_ready = 1'b1;
    for (int x = 40; x < 48; x++) begin
      in_valid = 1'b1;
      in_x = IN_W'(x);
      @(negedge clk);
      check(vld == 3'b111, "R2", "streaming valid", int'(vld), 7);
      check_triple(x);
    end
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    check(vld == 3'b000, "R2", "stream drained", int'(vld), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule